// File: doc/BRIEF.md
# Program-Status Polling Read Path

This block builds the byte a host sees when it reads a nonvolatile memory while an internal program or erase cycle may be running. While the write controller reports the part as busy, the read bus carries a completion-detect pattern instead of array contents. One bit returns the complement of the matching bit of the byte loaded last. A second bit flips from one read access to the next. Software may poll either bit to find the end of the cycle. When busy drops, the array data passes through unchanged, so the polled bit reads back its true stored value and the flipping bit stops.

The block also decodes the bus enables. The data outputs are driven only while chip enable and output enable are both low, and the block reports this on an output-enable line for the pad driver. The toggle flip-flop moves once per read access, at the moment the access begins, and not once per clock. It is cleared at the start of every new busy period. The array storage and the programming timer belong to other blocks.

Top module: `prog_status_readout`

## Requirements
- R1: `dq_oe_o` is 1 exactly when `ce_n_i` and `oe_n_i` are both 0; whenever it is 0, `dq_o` is all zeros.
- R2: During an enabled read with `busy_i` high, bit 7 of `dq_o` equals the inverse of `last_poll_bit_i` (the bit 7 of the byte loaded last).
- R3: While `busy_i` stays high, bit 6 of `dq_o` takes opposite values on successive read accesses. A read access begins at the first clock edge that sees both enables low after an edge that did not.
- R4: On the first clock edge that sees `busy_i` high after one that saw it low, the toggle state becomes 0. This holds even if a read access begins at the same edge, so that access reads bit 6 as 0 and the next one reads 1.
- R5: During an enabled read with `busy_i` high, bits 5 down to 0 of `dq_o` are 0.
- R6: During an enabled read with `busy_i` low, `dq_o` equals `array_data_i` on every bit, and read accesses do not change the toggle state.
- R7: The toggle state does not change while an access is held for several cycles, nor while only one of the two enables is low.
- R8: After reset, with both enables high, `dq_oe_o` is 0 and `dq_o` is 0. The toggle state and the edge history are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| busy_i | input | 1 | Internal program/erase cycle in progress |
| last_poll_bit_i | input | 1 | Polled bit of the byte loaded last |
| array_data_i | input | DW | Data read from the array |
| dq_o | output | DW | Read data toward the pads |
| dq_oe_o | output | 1 | Pad driver enable (0 means high impedance) |

## Verification
The output-enable decode, the inverted poll bit, the fill bits and the array pass-through are combinational, so they are valid in the same cycle as the inputs that set them. Bit 6 shows the toggle state. That state is written at the clock edge that first sees a new access or a busy rise, and the new value appears one edge after the stimulus. The bench applies inputs at the falling clock edge. At the rising edge it updates its own model of the toggle state and of the enable and busy history. It compares the outputs 1 ns after that rising edge, when both the combinational paths and the new register value have settled.

// File: rtl/prs_pkg.sv
package prs_pkg;

   // Source chosen for each bit of the read word while busy is high
   typedef enum logic [1:0] {
      SRC_FILL = 2'd0,
      SRC_POLL = 2'd1,
      SRC_TOG  = 2'd2
   } busy_src_e;

   function automatic busy_src_e busy_src_of(input int idx, input int poll_idx,
                                             input int tog_idx);
      if (idx == poll_idx)     return SRC_POLL;
      else if (idx == tog_idx) return SRC_TOG;
      else                     return SRC_FILL;
   endfunction

endpackage

// File: rtl/prs_edge_track.sv
module prs_edge_track (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n_i,
   input  logic oe_n_i,
   input  logic busy_i,
   output logic strobe_o,
   output logic access_start_o,
   output logic busy_rise_o
);

   logic strobe_q;
   logic busy_q;

   assign strobe_o       = ~ce_n_i & ~oe_n_i;
   assign access_start_o = strobe_o & ~strobe_q;
   assign busy_rise_o    = busy_i & ~busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         busy_q   <= 1'b0;
      end else begin
         strobe_q <= strobe_o;
         busy_q   <= busy_i;
      end
   end

   AST_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      access_start_o |=> !access_start_o);   // R3

   AST_RISE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_rise_o |=> !busy_rise_o);         // R4

endmodule

// File: rtl/prs_toggle.sv
module prs_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_i,
   input  logic busy_rise_i,
   input  logic access_start_i,
   output logic tog_o
);

   logic tog_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q <= 1'b0;
      end else if (busy_rise_i) begin
         tog_q <= 1'b0;
      end else if (busy_i && access_start_i) begin
         tog_q <= ~tog_q;
      end
   end

   assign tog_o = tog_q;

   AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !busy_rise_i && access_start_i) |=> (tog_o != $past(tog_o)));   // R3

   AST_TOG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      busy_rise_i |=> !tog_o);                                                   // R4

   AST_TOG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_i |=> $stable(tog_o));                                               // R6

   AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_rise_i && !access_start_i) |=> $stable(tog_o));                     // R7

endmodule

// File: rtl/prs_readmux.sv
module prs_readmux
   import prs_pkg::*;
#(
   parameter int          DW       = 8,
   parameter int          POLL_BIT = 7,
   parameter int          TOG_BIT  = 6,
   parameter logic [DW-1:0] FILL_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n_i,
   input  logic          oe_n_i,
   input  logic          busy_i,
   input  logic          last_poll_i,
   input  logic          tog_i,
   input  logic [DW-1:0] array_i,
   output logic [DW-1:0] dq_o,
   output logic          dq_oe_o
);

   localparam logic [DW-1:0] KEEP_MASK =
      ~((DW'(1) << POLL_BIT) | (DW'(1) << TOG_BIT));

   logic [DW-1:0] busy_word;
   logic [DW-1:0] sel_word;
   logic          drive;

   for (genvar i = 0; i < DW; i++) begin : g_bit
      localparam busy_src_e SRC = busy_src_of(i, POLL_BIT, TOG_BIT);
      if (SRC == SRC_POLL) begin : g_poll
         assign busy_word[i] = ~last_poll_i;
      end else if (SRC == SRC_TOG) begin : g_tog
         assign busy_word[i] = tog_i;
      end else begin : g_fill
         assign busy_word[i] = FILL_VAL[i];
      end
   end

   assign drive    = ~(ce_n_i | oe_n_i);
   assign sel_word = busy_i ? busy_word : array_i;
   assign dq_o     = drive ? sel_word : '0;
   assign dq_oe_o  = drive;

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n_i || oe_n_i) |-> (!dq_oe_o && dq_o == '0));                         // R1

   AST_POLL_INV: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe_o && busy_i) |-> (dq_o[POLL_BIT] == !last_poll_i));                 // R2

   AST_FILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe_o && busy_i) |-> ((dq_o & KEEP_MASK) == (FILL_VAL & KEEP_MASK)));   // R5

   AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe_o && !busy_i) |-> (dq_o == array_i));                               // R6

endmodule

// File: rtl/prog_status_readout.sv
module prog_status_readout #(
   parameter int            DW       = 8,
   parameter int            POLL_BIT = 7,
   parameter int            TOG_BIT  = 6,
   parameter logic [DW-1:0] FILL_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n_i,
   input  logic          oe_n_i,
   input  logic          busy_i,
   input  logic          last_poll_bit_i,
   input  logic [DW-1:0] array_data_i,
   output logic [DW-1:0] dq_o,
   output logic          dq_oe_o
);

   if (DW < 2) begin : g_chk_dw
      $error("prog_status_readout: DW must be at least 2");
   end
   if (POLL_BIT < 0 || POLL_BIT >= DW || TOG_BIT < 0 || TOG_BIT >= DW) begin : g_chk_idx
      $error("prog_status_readout: status bit index outside the data word");
   end
   if (POLL_BIT == TOG_BIT) begin : g_chk_dup
      $error("prog_status_readout: poll and toggle bits must differ");
   end

   logic strobe;
   logic access_start;
   logic busy_rise;
   logic tog;

   prs_edge_track u_edge (
      .clk            (clk),
      .rst_n          (rst_n),
      .ce_n_i         (ce_n_i),
      .oe_n_i         (oe_n_i),
      .busy_i         (busy_i),
      .strobe_o       (strobe),
      .access_start_o (access_start),
      .busy_rise_o    (busy_rise)
   );

   prs_toggle u_tog (
      .clk            (clk),
      .rst_n          (rst_n),
      .busy_i         (busy_i),
      .busy_rise_i    (busy_rise),
      .access_start_i (access_start),
      .tog_o          (tog)
   );

   prs_readmux #(
      .DW       (DW),
      .POLL_BIT (POLL_BIT),
      .TOG_BIT  (TOG_BIT),
      .FILL_VAL (FILL_VAL)
   ) u_mux (
      .clk         (clk),
      .rst_n       (rst_n),
      .ce_n_i      (ce_n_i),
      .oe_n_i      (oe_n_i),
      .busy_i      (busy_i),
      .last_poll_i (last_poll_bit_i),
      .tog_i       (tog),
      .array_i     (array_data_i),
      .dq_o        (dq_o),
      .dq_oe_o     (dq_oe_o)
   );

   AST_OE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> dq_oe_o);   // R1

endmodule

// File: tb/sim_prog_status_readout.sv
`timescale 1ns/1ps
module sim_prog_status_readout;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1;
   logic          oe_n = 1'b1;
   logic          busy = 1'b0;
   logic          lastb = 1'b0;
   logic [DW-1:0] arr = '0;
   logic [DW-1:0] dq;
   logic          dq_oe;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // bench model state
   logic m_tog = 1'b0;
   logic m_busy_q = 1'b0;
   logic m_strobe_q = 1'b0;

   always #2 clk = ~clk;

   prog_status_readout #(.DW(DW)) u0 (
      .clk             (clk),
      .rst_n           (rst_n),
      .ce_n_i          (ce_n),
      .oe_n_i          (oe_n),
      .busy_i          (busy),
      .last_poll_bit_i (lastb),
      .array_data_i    (arr),
      .dq_o            (dq),
      .dq_oe_o         (dq_oe)
   );

   function automatic logic [DW-1:0] exp_dq(input logic b, input logic c, input logic o,
                                            input logic lb, input logic [DW-1:0] a,
                                            input logic t);
      if (c || o) return '0;
      if (b)      return {~lb, t, 6'b0};
      return a;
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      logic s;
      s = ~ce_n & ~oe_n;
      if (!rst_n) begin
         m_tog = 1'b0; m_busy_q = 1'b0; m_strobe_q = 1'b0;
      end else begin
         if (busy && !m_busy_q)              m_tog = 1'b0;
         else if (busy && s && !m_strobe_q)  m_tog = ~m_tog;
         m_busy_q   = busy;
         m_strobe_q = s;
      end
   endtask

   task automatic step(input logic b, input logic c, input logic o,
                       input logic lb, input logic [DW-1:0] a, input string tag);
      @(negedge clk);
      busy = b; ce_n = c; oe_n = o; lastb = lb; arr = a;
      @(posedge clk);
      model_edge();
      #1;
      chk(tag, dq, exp_dq(b, c, o, lb, a, m_tog));
      chk({tag, " oe"}, {7'b0, dq_oe}, {7'b0, ~c & ~o});
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] first6;
      void'($urandom(32'h5eed_1234));
      // R8 reset state
      repeat (3) @(posedge clk);
      #1;
      chk("R8 reset dq", dq, '0);
      chk("R8 reset oe", {7'b0, dq_oe}, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); model_edge(); #1;

      // R6 idle pass-through
      step(0, 0, 0, 1, 8'hA5, "R6 idle read");
      step(0, 1, 1, 1, 8'hA5, "R1 idle off");
      step(0, 0, 0, 1, 8'h3C, "R6 idle read2");

      // R4 busy rise clears toggle, R3 alternation
      step(1, 1, 1, 1, 8'hFF, "R4 busy rise");
      step(1, 0, 0, 1, 8'hFF, "R3 first access");   // expect bit6 = 1
      chk("R3 first read bit6", {7'b0, dq[6]}, 8'h01);
      chk("R2 poll inverted", {7'b0, dq[7]}, 8'h00);
      chk("R5 fill zero", {2'b0, dq[5:0]}, 8'h00);
      // R7 hold access several cycles
      repeat (4) step(1, 0, 0, 1, 8'hFF, "R7 held access");
      step(1, 1, 1, 0, 8'h12, "R1 busy off");
      step(1, 0, 0, 0, 8'h12, "R3 second access");
      chk("R3 second read bit6", {7'b0, dq[6]}, 8'h00);
      chk("R2 poll inverted lb0", {7'b0, dq[7]}, 8'h01);
      // R7 only one enable low: no access
      step(1, 0, 1, 0, 8'h12, "R7 ce only");
      step(1, 1, 0, 0, 8'h12, "R7 oe only");
      step(1, 0, 0, 0, 8'h12, "R7 after partial");
      chk("R7 bit6 after partial", {7'b0, dq[6]}, 8'h01);

      // busy ends: R6 array data, toggle frozen
      step(0, 1, 1, 1, 8'h80, "R6 end off");
      step(0, 0, 0, 1, 8'h80, "R6 true bit7");
      chk("R6 bit7 true", {7'b0, dq[7]}, 8'h01);
      step(0, 1, 1, 1, 8'h80, "R6 gap");
      step(0, 0, 0, 1, 8'h40, "R6 again");

      // R4 busy rise at same edge as access start
      step(1, 0, 0, 1, 8'h00, "R4 coincident");
      chk("R4 coincident bit6", {7'b0, dq[6]}, 8'h00);
      step(1, 1, 1, 1, 8'h00, "R4 gap");
      step(1, 0, 0, 1, 8'h00, "R4 next access");
      chk("R4 next bit6", {7'b0, dq[6]}, 8'h01);
      first6 = dq;

      // constrained random mix
      for (int k = 0; k < 4000; k++) begin
         logic b, c, o;
         b = ($urandom % 16 == 0) ? ~busy : busy;
         c = ($urandom % 3 == 0);
         o = ($urandom % 3 == 0);
         step(b, c, o, 1'($urandom), DW'($urandom),
              b ? "R2 R3 R5 random" : "R1 R6 random");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule